// File: doc/BRIEF.md
# Timer Event Interrupt Flag Controller

This block sits between a timer and a processor's interrupt logic. Three single-cycle event pulses come from the timer: a compare match on channel A, a compare match on channel B, and the counter wrapping back to zero. Each pulse sets a sticky status flag. Software can read the flags and poll them, and it clears any of them by writing ones to the flag bits.

A second writable register holds one enable bit per source. A flag takes part in arbitration only when its enable bit is set. The request line reaches the core only while the global interrupt enable input is high. When several enabled flags are pending, a fixed priority picks the vector index to report. When the core accepts an interrupt, it returns the serviced index on the acknowledge port, and the matching flag clears in hardware.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset all flags and all enable bits are 0, `irqReq` is 0 and `irqIdx` is 0.
- R2: A 1 on `evtPulse[i]` sets flag i, and the flag is visible on `flagsOut[i]` after the next rising edge. The bit positions are 0 for the compare A match, 1 for the compare B match and 2 for the overflow.
- R3: A write with `wrSel`=0 clears every flag whose `wrData` bit is 1. Flags whose `wrData` bit is 0 keep their value.
- R4: If an event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R5: A write with `wrSel`=1 loads `wrData` into the enable register. A flag still sets while its enable bit is 0, and it can be read on `flagsOut`.
- R6: `irqReq` is 1 only when `globalEn` is 1 and at least one flag is set together with its enable bit. The output follows `globalEn` in the same cycle.
- R7: `irqIdx` gives the lowest bit position among the pending enabled flags, so the order is compare A, then compare B, then overflow. It is 0 when nothing is pending.
- R8: `ackValid` with `ackIdx`=k clears flag k at the next edge. An index of 3 has no effect, and an event on flag k in the same cycle wins over the acknowledge.
- R9: In a cycle with no event, no clearing write and no acknowledge, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 3 | Event pulses: bit0 compare A, bit1 compare B, bit2 overflow |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 is the flag register (write-1-to-clear), 1 is the enable register |
| wrData | input | 3 | Write data, one bit per source |
| globalEn | input | 1 | Global interrupt enable |
| ackValid | input | 1 | Interrupt accepted |
| ackIdx | input | 2 | Vector index of the accepted interrupt |
| flagsOut | output | 3 | Current flag values |
| irqReq | output | 1 | Interrupt request |
| irqIdx | output | 2 | Index of the highest-priority pending vector |

## Verification
The bench uses the default of three sources and a 2-bit index. With this setting the unused index value 3 exists, so the bench can show that acknowledging a nonexistent vector does nothing. Three sources are also enough to show every priority pair. A behavioural model is compared on every clock against the flags, the request and the index. The directed cycles cover simultaneous events, a set colliding with a clear, and the global enable gating. A pseudo-random stretch then mixes events, writes and acknowledges.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned EVT_COUNT = 3;
  localparam int unsigned VEC_W = (EVT_COUNT > 1) ? $clog2(EVT_COUNT) : 1;

  typedef struct packed {
    logic [EVT_COUNT-1:0] flagClr;
    logic                 maskLoad;
  } evt_strobe_t;
endpackage

// File: rtl/evt_irq_control.sv
module evt_irq_control
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [EVT_COUNT-1:0] wrData,
  input  logic                 ackValid,
  input  logic [VEC_W-1:0]     ackIdx,
  input  logic                 globalEn,
  input  logic [EVT_COUNT-1:0] pendVec,
  output evt_strobe_t          strb,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqIdx
);
  logic [EVT_COUNT-1:0] ackOneHot;
  logic                 found;

  always_comb begin
    ackOneHot = '0;
    for (int i = 0; i < EVT_COUNT; i++) begin
      if (ackValid && (ackIdx == VEC_W'(i))) ackOneHot[i] = 1'b1;
    end
    strb.flagClr  = ((wrEn && !wrSel) ? wrData : '0) | ackOneHot;
    strb.maskLoad = wrEn && wrSel;
  end

  always_comb begin
    irqIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < EVT_COUNT; i++) begin
      if (!found && pendVec[i]) begin
        irqIdx = VEC_W'(i);
        found  = 1'b1;
      end
    end
  end

  assign irqReq = globalEn && found;

  // R7
  priority_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendVec[irqIdx] &&
               ((pendVec & ((EVT_COUNT'(1) << irqIdx) - EVT_COUNT'(1))) == '0)));

  // R6
  gated_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalEn && (pendVec != '0)));
endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EVT_COUNT-1:0] evtPulse,
  input  logic [EVT_COUNT-1:0] wrData,
  input  evt_strobe_t          strb,
  output logic [EVT_COUNT-1:0] flagQ,
  output logic [EVT_COUNT-1:0] pendVec
);
  logic [EVT_COUNT-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= (flagQ & ~strb.flagClr) | evtPulse;
      if (strb.maskLoad) maskQ <= wrData;
    end
  end

  assign pendVec = flagQ & maskQ;

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskLoad |=> (maskQ == $past(wrData)));

  for (genvar b = 0; b < EVT_COUNT; b++) begin : g_flagChk
    // R2 R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[b] |=> flagQ[b]);
    // R3 R8
    clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.flagClr[b] && !evtPulse[b]) |=> !flagQ[b]);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.flagClr[b] && !evtPulse[b]) |=> (flagQ[b] == $past(flagQ[b])));
  end
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EVT_COUNT-1:0] evtPulse,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [EVT_COUNT-1:0] wrData,
  input  logic                 globalEn,
  input  logic                 ackValid,
  input  logic [VEC_W-1:0]     ackIdx,
  output logic [EVT_COUNT-1:0] flagsOut,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqIdx
);
  evt_strobe_t          strb;
  logic [EVT_COUNT-1:0] pendVec;

  evt_irq_control u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ackValid(ackValid), .ackIdx(ackIdx), .globalEn(globalEn),
    .pendVec(pendVec), .strb(strb), .irqReq(irqReq), .irqIdx(irqIdx)
  );

  evt_irq_datapath u_datapath (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrData(wrData),
    .strb(strb), .flagQ(flagsOut), .pendVec(pendVec)
  );
endmodule

// File: tb/timer_irq_flags_bench.sv
module timer_irq_flags_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] evtPulse = '0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [2:0] wrData = '0;
  logic       globalEn = 1'b0;
  logic       ackValid = 1'b0;
  logic [1:0] ackIdx = '0;
  logic [2:0] flagsOut;
  logic       irqReq;
  logic [1:0] irqIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit refFlags[3];
  bit refMask[3];

  always #10 clk = ~clk;

  timer_irq_flags u_timer_irq_flags (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .globalEn(globalEn), .ackValid(ackValid), .ackIdx(ackIdx),
    .flagsOut(flagsOut), .irqReq(irqReq), .irqIdx(irqIdx)
  );

  task automatic compare(input string tag);
    int expFlags = 0;
    int expReq = 0;
    int expIdx = 0;
    bit seen = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (refFlags[i]) expFlags += (1 << i);
      if (refFlags[i] && refMask[i] && !seen) begin
        seen = 1'b1;
        expIdx = i;
      end
    end
    expReq = (globalEn && seen) ? 1 : 0;
    checks += 3;
    if (int'(flagsOut) != expFlags) begin
      fails++;
      $display("FAIL %s flags actual=%0d expected=%0d", tag, flagsOut, expFlags);
    end
    if (int'(irqReq) != expReq) begin
      fails++;
      $display("FAIL %s irqReq actual=%0d expected=%0d", tag, irqReq, expReq);
    end
    if (int'(irqIdx) != expIdx) begin
      fails++;
      $display("FAIL %s irqIdx actual=%0d expected=%0d", tag, irqIdx, expIdx);
    end
  endtask

  task automatic cyc(input logic [2:0] ev, input logic we, input logic ws,
                     input logic [2:0] wd, input logic ge, input logic av,
                     input logic [1:0] ai, input string tag);
    evtPulse = ev; wrEn = we; wrSel = ws; wrData = wd;
    globalEn = ge; ackValid = av; ackIdx = ai;
    #5;
    compare(tag);
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      if (ev[i]) refFlags[i] = 1'b1;
      else if ((we && !ws && wd[i]) || (av && int'(ai) == i)) refFlags[i] = 1'b0;
      if (we && ws) refMask[i] = wd[i];
    end
    @(negedge clk);
  endtask

  initial begin
    int seed = 7;
    for (int i = 0; i < 3; i++) begin refFlags[i] = 0; refMask[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(3'b000, 0, 0, 3'b000, 1, 0, 0, "R1");
    cyc(3'b100, 0, 0, 3'b000, 1, 0, 0, "R2");
    cyc(3'b011, 0, 0, 3'b000, 1, 0, 0, "R5");
    cyc(3'b000, 0, 0, 3'b010, 1, 0, 0, "R2");
    cyc(3'b000, 1, 0, 3'b010, 1, 0, 0, "R3");
    cyc(3'b001, 1, 0, 3'b001, 0, 0, 0, "R4");
    cyc(3'b000, 1, 1, 3'b111, 0, 0, 0, "R5");
    cyc(3'b010, 0, 0, 3'b000, 0, 0, 0, "R6");
    cyc(3'b000, 0, 0, 3'b000, 1, 0, 0, "R7");
    cyc(3'b000, 0, 0, 3'b000, 1, 1, 0, "R8");
    cyc(3'b000, 0, 0, 3'b000, 1, 1, 3, "R8");
    cyc(3'b000, 0, 0, 3'b000, 1, 1, 1, "R7");
    cyc(3'b100, 0, 0, 3'b000, 1, 1, 2, "R8");
    cyc(3'b000, 1, 1, 3'b100, 1, 0, 0, "R7");
    cyc(3'b000, 0, 0, 3'b000, 0, 0, 0, "R9");
    cyc(3'b000, 0, 0, 3'b000, 1, 1, 2, "R8");
    cyc(3'b000, 0, 0, 3'b000, 1, 0, 0, "R6");
    for (int n = 0; n < 300; n++) begin
      seed = seed * 1103515245 + 12345;
      cyc(3'((seed >>> 8) & (((seed >>> 20) & 3) == 0 ? 7 : 0)),
          ((seed >>> 11) & 3) == 0, (seed >>> 13) & 1, 3'(seed >>> 14),
          (seed >>> 17) & 1, ((seed >>> 18) & 3) == 0, 2'(seed >>> 22), "R9");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule